// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C target that behaves like a 512-byte serial EEPROM with 8-bit words. A fast system clock oversamples the bus lines through synchronizers. START, repeated START and STOP are recognised as SDA edges while SCL is high. Incoming bits are captured on SCL rising edges, and the block changes SDA only after it has seen SCL go low. SDA is driven open-drain: `sda_oe` high means "pull SDA low". The bus wiring outside the block combines this pull-down with the pull-ups of the rest of the bus.

A transfer opens with a device byte. That byte carries a fixed 6-bit prefix, then word-address bit 8, then the direction bit. A write carries address bits 7:0 in the next byte and data bytes after that. Data bytes fill a 16-byte page, and the low four address bits wrap inside the page. A read returns bytes starting at an internal pointer. The pointer always holds the last accessed address plus one, and it wraps from 511 to 0. The read goes on for as long as the controller acknowledges. A random read is a write that stops after the address byte, followed by a repeated START and a read. When a STOP ends a write that stored at least one byte, the block models the programming time. For `WRITE_BUSY_CYC` system cycles it does not acknowledge its device byte, so a controller can poll it.

The control is one state machine with nine states:
- `ST_IDLE` waits for a START.
- `ST_DEV` receives the device byte. It moves to `ST_DEV_ACK` on a match while not busy, and otherwise back to `ST_IDLE`.
- `ST_DEV_ACK` moves to `ST_TX` for a read or to `ST_WADDR` for a write.
- `ST_WADDR` moves to `ST_WADDR_ACK`, and `ST_WADDR_ACK` moves to `ST_WDATA`.
- `ST_WDATA` and `ST_WDATA_ACK` alternate for each data byte.
- `ST_TX` moves to `ST_TX_ACK` after eight bits. `ST_TX_ACK` returns to `ST_TX` when the controller acknowledges, and goes to `ST_IDLE` when it does not.

A STOP in any state leads to `ST_IDLE`, and a START in any state leads to `ST_DEV`.

Top module: `i2c_ee_target`

## Requirements
- R1: After reset, and whenever the block is idle, `sda_oe` is 0 (SDA released).
- R2: A device byte whose upper six bits (MSB first) are not 101000 gets no ACK. Further bytes are ignored and `sda_oe` stays 0 until the next START.
- R3: A device byte with bit 0 = 0 (write) is acknowledged by pulling SDA low in the 9th clock. Bit 1 of the device byte is address bit 8, and the next byte gives address bits 7:0. Each following data byte is acknowledged and stored at the pointer.
- R4: After each stored data byte, the pointer's low 4 bits increment modulo 16 while bits 8:4 stay fixed. A write of more than 16 bytes therefore overwrites earlier bytes of the same page.
- R5: A write that stops after the address byte, followed by a repeated START and a device byte with bit 0 = 1, returns the byte stored at that address.
- R6: During a read, each byte the controller acknowledges (SDA low in the 9th clock) is followed by the byte at the next address, and address 511 is followed by address 0. A NAK (SDA high) ends the transfer and leaves SDA released.
- R7: A read that is not preceded by an address byte starts at the last accessed address plus one.
- R8: After a STOP that ends a write with at least one stored data byte, the device byte is not acknowledged for `WRITE_BUSY_CYC` cycles. After that it is acknowledged again.
- R9: Read data goes out MSB first, and the block starts pulling SDA low only while SCL is low.
- R10: A STOP in the middle of a byte returns the block to idle with SDA released. A partial byte is not stored and does not start a busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| sda_oe | output | 1 | 1 = pull SDA low, 0 = release SDA |

## Verification
The bench builds the block with `WRITE_BUSY_CYC` = 3000 instead of a millisecond-scale default. This keeps every busy window short, so a poll NAK during the window and an ACK after it both fit in one short run, together with several writes. The page size and memory depth keep their defaults. A 16-byte page overflow and a read that wraps from 511 to 0 therefore take only a few bytes each. The bench runs the bus with a quarter bit period of 10 system clocks, well above the synchronizer and edge-detect latency.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_TX,
        ST_TX_ACK
    } ee_state_t;

endpackage

// File: rtl/i2c_ee_bus_sense.sv
module i2c_ee_bus_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int STG = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    logic [STG-1:0] scl_pipe;
    logic [STG-1:0] sda_pipe;
    logic           scl_q;
    logic           sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STG-2:0], scl_i};
            sda_pipe <= {sda_pipe[STG-2:0], sda_i};
            scl_q    <= scl_pipe[STG-1];
            sda_q    <= sda_pipe[STG-1];
        end
    end

    assign scl_lvl   = scl_pipe[STG-1];
    assign sda_lvl   = sda_pipe[STG-1];
    assign scl_rise  = scl_lvl & ~scl_q;
    assign scl_fall  = ~scl_lvl & scl_q;
    // SDA edges while SCL stays high on both samples
    assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/i2c_ee_store.sv
module i2c_ee_store #(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/i2c_ee_busy_timer.sv
module i2c_ee_busy_timer #(
    parameter int BUSY_CYC = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic busy
);
    generate
        if (BUSY_CYC > 0) begin : g_timer
            localparam int CW = $clog2(BUSY_CYC + 1);
            logic [CW-1:0] remain;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    remain <= '0;
                end else if (kick) begin
                    remain <= CW'(BUSY_CYC);
                end else if (remain != '0) begin
                    remain <= remain - 1'b1;
                end
            end

            assign busy = (remain != '0);
        end else begin : g_none
            logic unused_kick;
            assign unused_kick = kick;
            assign busy = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/i2c_ee_target.sv
module i2c_ee_target
    import i2c_ee_pkg::*;
#(
    parameter logic [5:0] DEV_PREFIX     = 6'b101000,
    parameter int         PAGE_BYTES     = 16,
    parameter int         WRITE_BUSY_CYC = 1_000_000,
    parameter int         SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    localparam int DATA_W = 8;
    localparam int ADDR_W = DATA_W + 1;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int PAGE_W = $clog2(PAGE_BYTES);

    // bus event detection
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    i2c_ee_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    ee_state_t          state, nxt;
    logic [2:0]         bit_cnt;
    logic [DATA_W-2:0]  rx_sr;
    logic [DATA_W-2:0]  tx_sr;
    logic [ADDR_W-1:0]  ptr;
    logic               slot_hi;
    logic               is_read;
    logic               dev_hi;
    logic               wr_pending;
    logic               busy;
    logic [DATA_W-1:0]  byte_in;
    logic [DATA_W-1:0]  rd_byte;
    logic               last_bit;
    logic               prefix_ok;
    logic               mem_we;
    logic               busy_kick;

    assign byte_in   = {rx_sr, sda_lvl};
    assign last_bit  = scl_rise && (bit_cnt == 3'd7);
    assign prefix_ok = (byte_in[DATA_W-1:2] == DEV_PREFIX);
    assign mem_we    = (state == ST_WDATA) && last_bit && !start_det && !stop_det;
    assign busy_kick = stop_det && wr_pending;

    i2c_ee_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (ptr),
        .wdata (byte_in),
        .raddr (ptr),
        .rdata (rd_byte)
    );

    i2c_ee_busy_timer #(.BUSY_CYC(WRITE_BUSY_CYC)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .kick  (busy_kick),
        .busy  (busy)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        if (stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_DEV;
        end else begin
            unique case (state)
                ST_IDLE: nxt = ST_IDLE;
                ST_DEV: begin
                    if (last_bit) begin
                        nxt = (prefix_ok && !busy) ? ST_DEV_ACK : ST_IDLE;
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall && slot_hi) begin
                        nxt = is_read ? ST_TX : ST_WADDR;
                    end
                end
                ST_WADDR: begin
                    if (last_bit) nxt = ST_WADDR_ACK;
                end
                ST_WADDR_ACK: begin
                    if (scl_fall && slot_hi) nxt = ST_WDATA;
                end
                ST_WDATA: begin
                    if (last_bit) nxt = ST_WDATA_ACK;
                end
                ST_WDATA_ACK: begin
                    if (scl_fall && slot_hi) nxt = ST_WDATA;
                end
                ST_TX: begin
                    if (last_bit) nxt = ST_TX_ACK;
                end
                ST_TX_ACK: begin
                    if (scl_rise && sda_lvl) begin
                        nxt = ST_IDLE;
                    end else if (scl_fall && slot_hi) begin
                        nxt = ST_TX;
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // datapath and SDA drive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe     <= 1'b0;
            bit_cnt    <= '0;
            rx_sr      <= '0;
            tx_sr      <= '0;
            ptr        <= '0;
            slot_hi    <= 1'b0;
            is_read    <= 1'b0;
            dev_hi     <= 1'b0;
            wr_pending <= 1'b0;
        end else if (stop_det) begin
            sda_oe     <= 1'b0;
            slot_hi    <= 1'b0;
            wr_pending <= 1'b0;
        end else if (start_det) begin
            sda_oe  <= 1'b0;
            slot_hi <= 1'b0;
            bit_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    sda_oe <= 1'b0;
                end
                ST_DEV, ST_WADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        rx_sr   <= byte_in[DATA_W-2:0];
                        bit_cnt <= bit_cnt + 1'b1;
                        slot_hi <= 1'b0;
                    end
                    if (last_bit) begin
                        if (state == ST_DEV) begin
                            is_read <= byte_in[0];
                            dev_hi  <= byte_in[1];
                        end else if (state == ST_WADDR) begin
                            ptr <= {dev_hi, byte_in};
                        end else begin
                            ptr <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
                            wr_pending <= 1'b1;
                        end
                    end
                end
                ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: begin
                    if (scl_rise) begin
                        slot_hi <= 1'b1;
                    end
                    if (scl_fall && !slot_hi) begin
                        sda_oe <= 1'b1;
                    end else if (scl_fall && slot_hi) begin
                        slot_hi <= 1'b0;
                        bit_cnt <= '0;
                        if (state == ST_DEV_ACK && is_read) begin
                            tx_sr  <= rd_byte[DATA_W-2:0];
                            sda_oe <= ~rd_byte[DATA_W-1];
                            ptr    <= ptr + 1'b1;
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        bit_cnt <= bit_cnt + 1'b1;
                        slot_hi <= 1'b0;
                    end
                    if (scl_fall) begin
                        sda_oe <= ~tx_sr[DATA_W-2];
                        tx_sr  <= {tx_sr[DATA_W-3:0], 1'b0};
                    end
                end
                ST_TX_ACK: begin
                    if (scl_fall && !slot_hi) begin
                        sda_oe <= 1'b0;
                    end else if (scl_fall && slot_hi) begin
                        slot_hi <= 1'b0;
                        bit_cnt <= '0;
                        tx_sr   <= rd_byte[DATA_W-2:0];
                        sda_oe  <= ~rd_byte[DATA_W-1];
                        ptr     <= ptr + 1'b1;
                    end
                    if (scl_rise && !sda_lvl) begin
                        slot_hi <= 1'b1;
                    end
                end
                default: sda_oe <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/i2c_ee_checker.sv
module i2c_ee_checker
    import i2c_ee_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      scl_lvl,
    input logic      stop_det,
    input logic      sda_oe,
    input logic      busy,
    input logic      slot_hi,
    input ee_state_t state
);

    // R1: idle implies a released line
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    // R9: pull-down only begins while SCL is low
    a_r9_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(!scl_lvl));

    // R10: a STOP leaves the block idle with SDA released
    a_r10_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_oe));

    // R8: no device acknowledge while programming
    a_r8_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (state != ST_DEV_ACK));

    // R6: the controller's acknowledge slot is never driven by the block
    a_r6_master_slot_free: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX_ACK && slot_hi) |-> !sda_oe);

endmodule

bind i2c_ee_target i2c_ee_checker u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_lvl  (scl_lvl),
    .stop_det (stop_det),
    .sda_oe   (sda_oe),
    .busy     (busy),
    .slot_hi  (slot_hi),
    .state    (state)
);

// File: tb/i2c_ee_target_tb.sv
`timescale 1ns/1ps
module i2c_ee_target_tb_top;
    localparam int BUSY = 3000;
    localparam int Q    = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic done = 1'b0;
    int   oe_pulls = 0;

    always #2.5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    i2c_ee_target #(.WRITE_BUSY_CYC(BUSY)) dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_m),
        .sda_i  (sda_line),
        .sda_oe (sda_oe)
    );

    always @(posedge clk) if (sda_oe) oe_pulls <= oe_pulls + 1;

    // scoreboard
    logic [15:0] exp_v [$];
    string       exp_t [$];
    logic [15:0] obs_v [$];
    int n_checks = 0;
    int n_fail   = 0;

    task automatic expect_item(input string tag, input logic [15:0] v);
        exp_t.push_back(tag);
        exp_v.push_back(v);
    endtask

    task automatic observe(input logic [15:0] v);
        obs_v.push_back(v);
    endtask

    task automatic direct_check(input string tag, input logic [15:0] act, input logic [15:0] ex);
        expect_item(tag, ex);
        observe(act);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            while (obs_v.size() > 0 && exp_v.size() > 0) begin
                logic [15:0] a, e;
                string t;
                a = obs_v.pop_front();
                e = exp_v.pop_front();
                t = exp_t.pop_front();
                n_checks++;
                if (a !== e) begin
                    n_fail++;
                    $display("FAIL %s actual=%0h expected=%0h", t, a, e);
                end
            end
        end
    end

    // reference model
    logic [7:0] ref_mem [512];
    int ref_ptr = 0;

    // bus driver
    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; qwait();
            scl_m = 1'b1; qwait(); qwait();
            scl_m = 1'b0; qwait();
        end
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        ack = sda_line; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic recv_byte(input logic nak, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; qwait();
            scl_m = 1'b1; qwait();
            b[i] = sda_line; qwait();
            scl_m = 1'b0; qwait();
        end
        sda_m = nak; qwait();
        scl_m = 1'b1; qwait(); qwait();
        scl_m = 1'b0; qwait();
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] dev_byte(input logic a8, input logic rd);
        return {6'b101000, a8, rd};
    endfunction

    task automatic send_exp(input string tag, input logic [7:0] b, input logic ack_exp);
        logic ack;
        expect_item(tag, 16'(ack_exp));
        send_byte(b, ack);
        observe(16'(ack));
    endtask

    // page write of n bytes; data byte k = first + 7k
    task automatic page_write(input string tag, input logic [8:0] addr, input int n, input logic [7:0] first);
        logic [8:0] p;
        p = addr;
        bus_start();
        send_exp({tag, " dev ack"}, dev_byte(addr[8], 1'b0), 1'b0);
        send_exp({tag, " addr ack"}, addr[7:0], 1'b0);
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            d = first + 8'(7 * k);
            send_exp({tag, " data ack"}, d, 1'b0);
            ref_mem[p] = d;
            p = {p[8:4], p[3:0] + 4'd1};
        end
        ref_ptr = int'(p);
        bus_stop();
        // R8: poll during programming gets NAK
        bus_start();
        send_exp("R8 busy poll nak", dev_byte(1'b0, 1'b0), 1'b1);
        bus_stop();
        repeat (BUSY + 100) @(negedge clk);
    endtask

    task automatic read_bytes(input string tag, input int n);
        for (int k = 0; k < n; k++) begin
            logic [7:0] b;
            expect_item(tag, 16'(ref_mem[ref_ptr]));
            recv_byte(k == n - 1, b);
            observe(16'(b));
            ref_ptr = (ref_ptr + 1) % 512;
        end
        bus_stop();
    endtask

    task automatic random_read(input string tag, input logic [8:0] addr, input int n);
        bus_start();
        send_exp({tag, " dummy dev ack"}, dev_byte(addr[8], 1'b0), 1'b0);
        send_exp({tag, " dummy addr ack"}, addr[7:0], 1'b0);
        bus_start();
        send_exp({tag, " read dev ack"}, dev_byte(addr[8], 1'b1), 1'b0);
        ref_ptr = int'(addr);
        read_bytes(tag, n);
    endtask

    task automatic current_read(input string tag, input int n);
        bus_start();
        send_exp({tag, " dev ack"}, dev_byte(1'b0, 1'b1), 1'b0);
        read_bytes(tag, n);
    endtask

    initial begin : main
        int pulls0;
        repeat (10) @(negedge clk);
        direct_check("R1 sda released in reset", 16'(sda_oe), 16'd0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        direct_check("R1 sda released after reset", 16'(sda_oe), 16'd0);

        // R2: wrong prefix, following byte ignored
        pulls0 = oe_pulls;
        bus_start();
        send_exp("R2 wrong prefix nak", 8'hB0, 1'b1);
        send_exp("R2 later byte ignored", 8'h00, 1'b1);
        bus_stop();
        direct_check("R2 no pull during foreign transfer", 16'(oe_pulls - pulls0), 16'd0);

        // R3: byte writes with A8 in device byte bit 1
        page_write("R3 wr 0A5", 9'h0A5, 1, 8'h3C);
        bus_start();
        send_exp("R8 ack after busy window", dev_byte(1'b0, 1'b0), 1'b0);
        bus_stop();
        page_write("R3 wr 1A5", 9'h1A5, 1, 8'hC3);
        random_read("R5 R3 read 0A5", 9'h0A5, 1);
        random_read("R5 R3 read 1A5", 9'h1A5, 1);

        // R7: current-address read continues after last access
        page_write("R3 wr 103", 9'h103, 2, 8'h11);
        random_read("R5 read 103", 9'h103, 1);
        current_read("R7 current read 104", 1);

        // R4: page overflow wraps inside the page
        page_write("R4 page wr", 9'h0E4, 18, 8'h40);
        random_read("R4 R9 page readback", 9'h0E0, 16);

        // R6: sequential read wraps 511 -> 0
        page_write("R6 wr top", 9'h1FE, 2, 8'hA0);
        page_write("R6 wr bottom", 9'h000, 2, 8'h5A);
        random_read("R6 wrap read", 9'h1FE, 4);

        // R10: STOP inside a data byte
        page_write("R10 wr 040", 9'h040, 1, 8'h77);
        bus_start();
        send_exp("R10 dev ack", dev_byte(1'b0, 1'b0), 1'b0);
        send_exp("R10 addr ack", 8'h40, 1'b0);
        for (int i = 7; i >= 4; i--) begin
            sda_m = 1'b0; qwait();
            scl_m = 1'b1; qwait(); qwait();
            scl_m = 1'b0; qwait();
        end
        bus_stop();
        qwait();
        direct_check("R10 sda released after stop", 16'(sda_oe), 16'd0);
        bus_start();
        send_exp("R10 no busy after partial byte", dev_byte(1'b0, 1'b0), 1'b0);
        bus_stop();
        random_read("R10 partial byte not stored", 9'h040, 1);

        repeat (20) @(negedge clk);
        direct_check("scoreboard drained", 16'(exp_v.size()), 16'd0);
        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks + 1, n_fail + 1);
            $finish;
        end
    end

endmodule